// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

A single-port synchronous static memory with a registered two-stage pipeline. A command is captured on one rising edge: address, access kind, the byte lanes to write and the write data. The next rising edge performs the array access. A read lands in an output register, and a write updates the addressed lanes. The data bus is split into four equal byte lanes. With a 36-bit bus each lane carries one extra bit, which is stored and returned with its lane and never checked.

An access starts with one of two address strobes, and three chip enables gate it. Write lanes come from a global-write override or from a byte-write enable combined with per-lane enables. Between strobes, a selected device repeats the access at the held address. It reads again if no lane enable is active and writes the enabled lanes if one is. The external burst counter and power-down sequencer are separate blocks.

The data bus is presented as a separate input, a registered output and a drive-enable for the pad. The drive-enable follows the active-low output enable combinationally. It is also forced off while a write is registered, and it stays on for one extra cycle after a deselect drains the pipeline.

Top module: `sync_sram_pipe`

## Requirements
- R1: A read whose address is captured at rising edge N presents that word on `q_o` after edge N+1, with `dq_oe` high from edge N+1 while `oe_n` is low.
- R2: With `gw_n` low on a write-capable edge, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R3: With `gw_n` high, lane i (bits i*LANE_W to i*LANE_W+LANE_W-1) is written only when `bwe_n` is low and `bw_n[i]` is low. If no lane qualifies, the edge is a read.
- R4: An edge that starts an access through the processor strobe (`adsp_n` low with `ce0_n` low) is always a read. The write controls are ignored on that edge and are honoured on the following non-strobe edges.
- R5: On an edge that registers a write, the write data is captured, and `dq_oe` is low for the following cycle whatever `oe_n` is.
- R6: An access is selected only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0 on a strobe edge. A controller-strobe edge (`adsc_n` low, `adsp_n` high) with any enable inactive deselects. `adsp_n` low with `ce0_n` high starts nothing. Chip enables on non-strobe edges have no effect.
- R7: After a deselect captured at edge N, which follows a read, the last read word stays driven until edge N+2. From edge N+2 `dq_oe` is low unless a new access has started. After reset `dq_oe` is low.
- R8: `oe_n` acts combinationally: while it is high `dq_oe` is low, and when it falls during a read `dq_oe` rises in the same cycle.
- R9: A read of an address just written returns the new lanes and the old contents of the lanes that were not written.
- R10: With DATA_W=36, each lane's ninth bit is written and read together with its lane.
- R11: On non-strobe edges while selected, the access repeats at the held address: a read when no lane is enabled, otherwise a write of the enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address, captured on strobe edges |
| adsp_n | input | 1 | Processor address strobe, active low, blocked by `ce0_n` |
| adsc_n | input | 1 | Controller address strobe, active low, needs `adsp_n` high |
| ce0_n | input | 1 | Master chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte write enable, active low, qualifies `bw_n` |
| bw_n | input | 4 | Per-lane write enables, active low, bit i for lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_i | input | DATA_W | Write data |
| q_o | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Pad drive enable for `q_o` |

## Verification
The assertions check several rules on every cycle. Processor-strobe edges never register a write. A global-write edge on the controller strobe fills every lane and turns the drive off in the next cycle. A deselected strobe leaves the pipeline empty. A high `oe_n` never coexists with drive. The drive is gone three edges after a deselect that no strobe follows. A read captured on a processor strobe reaches the output register two edges later. Only the bench scenarios can show the data itself: lane merging under byte writes, parity bits travelling with their lanes, and read-after-write contents. They also show the mid-cycle response to `oe_n` and the repeated access between strobes, all compared cycle by cycle against a behavioural model.

// File: rtl/sram_pkg.sv
package sram_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } access_e;

endpackage

// File: rtl/sram_wdec.sv
module sram_wdec
  import sram_pkg::*;
(
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] bw_n,
  output logic [NUM_LANES-1:0] lanes_o
);

  // global write overrides; otherwise byte enable qualifies each lane
  always_comb begin
    if (!gw_n) begin
      lanes_o = '1;
    end else if (!bwe_n) begin
      lanes_o = ~bw_n;
    end else begin
      lanes_o = '0;
    end
  end

endmodule

// File: rtl/sram_cmd.sv
module sram_cmd
  import sram_pkg::*;
(
  input  logic                 adsp_n,
  input  logic                 adsc_n,
  input  logic                 ce0_n,
  input  logic                 ce1,
  input  logic                 ce2_n,
  input  logic [NUM_LANES-1:0] req_lanes,
  input  logic                 act_q,
  output logic                 strobe_o,
  output logic                 sel_o,
  output logic                 nx_act,
  output access_e              nx_kind,
  output logic [NUM_LANES-1:0] nx_lanes
);

  logic p_go;
  logic c_go;

  always_comb begin
    p_go     = ~adsp_n & ~ce0_n;
    c_go     = adsp_n & ~adsc_n;
    strobe_o = p_go | c_go;
    sel_o    = ~ce0_n & ce1 & ~ce2_n;

    nx_act   = act_q;
    nx_lanes = '0;
    nx_kind  = ACC_NONE;

    if (strobe_o) begin
      nx_act = sel_o;
      // processor strobe edges ignore the write controls
      if (c_go && sel_o) begin
        nx_lanes = req_lanes;
      end
      if (sel_o) begin
        nx_kind = (|nx_lanes) ? ACC_WRITE : ACC_READ;
      end
    end else if (act_q) begin
      nx_lanes = req_lanes;
      nx_kind  = (|req_lanes) ? ACC_WRITE : ACC_READ;
    end
  end

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 9,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata_q
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem[idx];
    end
  end

endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 36,
  parameter int DEPTH  = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 adsp_n,
  input  logic                 adsc_n,
  input  logic                 ce0_n,
  input  logic                 ce1,
  input  logic                 ce2_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] bw_n,
  input  logic                 oe_n,
  input  logic [DATA_W-1:0]    d_i,
  output logic [DATA_W-1:0]    q_o,
  output logic                 dq_oe
);

  localparam int LANE_W = DATA_W / NUM_LANES;
  localparam int IDX_W  = $clog2(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // command decode
  logic [NUM_LANES-1:0] req_lanes;
  logic                 strobe;
  logic                 sel;
  logic                 act_q;
  logic                 nx_act;
  access_e              nx_kind;
  logic [NUM_LANES-1:0] nx_lanes;

  sram_wdec u_wdec (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .lanes_o (req_lanes)
  );

  sram_cmd u_cmd (
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .ce0_n     (ce0_n),
    .ce1       (ce1),
    .ce2_n     (ce2_n),
    .req_lanes (req_lanes),
    .act_q     (act_q),
    .strobe_o  (strobe),
    .sel_o     (sel),
    .nx_act    (nx_act),
    .nx_kind   (nx_kind),
    .nx_lanes  (nx_lanes)
  );

  // stage 1: captured command
  access_e              s1_kind;
  logic [NUM_LANES-1:0] s1_lanes;
  logic [IDX_W-1:0]     s1_idx;
  logic [DATA_W-1:0]    s1_din;
  logic                 addr_en;
  logic                 din_en;
  logic                 unused_hi;

  assign addr_en   = strobe;
  assign din_en    = |nx_lanes;
  assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      act_q    <= 1'b0;
      s1_kind  <= ACC_NONE;
      s1_lanes <= '0;
    end else begin
      act_q    <= nx_act;
      s1_kind  <= nx_kind;
      s1_lanes <= nx_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      s1_idx <= addr_i[IDX_W-1:0];
    end
    if (din_en) begin
      s1_din <= d_i;
    end
  end

  // stage 2: array access and output register per lane
  logic s1_rd;
  assign s1_rd = (s1_kind == ACC_READ);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sram_lane #(
      .DEPTH  (DEPTH),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk     (clk),
      .we      (s1_lanes[g]),
      .re      (s1_rd),
      .idx     (s1_idx),
      .wdata   (s1_din[g*LANE_W +: LANE_W]),
      .rdata_q (q_o[g*LANE_W +: LANE_W])
    );
  end

  // output drive control with one-cycle deselect tail
  logic s2_vld;
  logic s2_tail;
  logic nx_vld;
  logic nx_tail;

  always_comb begin
    nx_vld  = s1_rd;
    nx_tail = s2_vld & (s1_kind == ACC_NONE);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s2_vld  <= 1'b0;
      s2_tail <= 1'b0;
    end else begin
      s2_vld  <= nx_vld;
      s2_tail <= nx_tail;
    end
  end

  assign dq_oe = ~oe_n & (s1_kind != ACC_WRITE) & (s2_vld | s2_tail);

  // assertions
  logic c_wr_all;
  logic dsel_cmd;
  logic p_rd_cmd;
  assign c_wr_all = ~adsc_n & adsp_n & sel & ~gw_n;
  assign dsel_cmd = strobe & ~sel;
  assign p_rd_cmd = ~adsp_n & ~ce0_n & sel;

  AST_ADSP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!adsp_n && !ce0_n) |=> (s1_lanes == '0)); // R4

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_core_n)
    c_wr_all |=> (&s1_lanes)); // R2

  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_core_n)
    c_wr_all |=> !dq_oe); // R5

  AST_DESEL_EMPTY: assert property (@(posedge clk) disable iff (!rst_core_n)
    dsel_cmd |=> (s1_kind == ACC_NONE)); // R6

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    oe_n |-> !dq_oe); // R8

  AST_DCD_RELEASE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($past(dsel_cmd, 3) && !$past(strobe, 2) && !$past(strobe, 1)) |-> !dq_oe); // R7

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_core_n)
    p_rd_cmd |=> ##1 s2_vld); // R1

endmodule

// File: tb/sim_sync_sram_pipe.sv
module sim_sync_sram_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 1024;
  localparam int LW     = DATA_W / 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              adsp_n = 1'b1;
  logic              adsc_n = 1'b1;
  logic              ce0_n = 1'b0;
  logic              ce1 = 1'b1;
  logic              ce2_n = 1'b0;
  logic              gw_n = 1'b1;
  logic              bwe_n = 1'b1;
  logic [3:0]        bw_n = 4'hF;
  logic              oe_n = 1'b0;
  logic [DATA_W-1:0] d_i = '0;
  logic [DATA_W-1:0] q_o;
  logic              dq_oe;

  sync_sram_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .d_i(d_i), .q_o(q_o), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R7";
  bit    done = 0;

  // behavioural reference model
  bit [DATA_W-1:0] mmem [int];
  bit [3:0]        mknown [int];
  int              m_kind = 0;   // 0 none, 1 read, 2 write
  bit              m_act = 0;
  bit [3:0]        m_lanes = 0;
  int              m_idx = 0;
  bit [DATA_W-1:0] m_din = 0;
  bit              m_vld = 0;
  bit              m_tail = 0;
  bit [DATA_W-1:0] m_dout = 0;
  bit [3:0]        m_dk = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0; m_act = 0; m_lanes = 0; m_vld = 0; m_tail = 0; m_dk = 0;
    end else begin
      bit nv, nt, pgo, cgo, sl;
      bit [3:0] rl;
      nv = (m_kind == 1);
      nt = m_vld && (m_kind == 0);
      if (m_kind == 1) begin
        m_dout = mmem.exists(m_idx) ? mmem[m_idx] : '0;
        m_dk   = mknown.exists(m_idx) ? mknown[m_idx] : 4'h0;
      end
      if (m_kind == 2) begin
        bit [DATA_W-1:0] w;
        w = mmem.exists(m_idx) ? mmem[m_idx] : '0;
        if (!mknown.exists(m_idx)) mknown[m_idx] = 4'h0;
        for (int i = 0; i < 4; i++) begin
          if (m_lanes[i]) begin
            w[i*LW +: LW] = m_din[i*LW +: LW];
            mknown[m_idx][i] = 1'b1;
          end
        end
        mmem[m_idx] = w;
      end
      m_vld = nv;
      m_tail = nt;
      pgo = !adsp_n && !ce0_n;
      cgo = adsp_n && !adsc_n;
      sl  = !ce0_n && ce1 && !ce2_n;
      rl  = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
      if (pgo || cgo) begin
        m_act   = sl;
        m_idx   = int'(addr_i) % DEPTH;
        m_lanes = (cgo && sl) ? rl : 4'h0;
        m_kind  = !sl ? 0 : ((m_lanes != 0) ? 2 : 1);
      end else if (m_act) begin
        m_lanes = rl;
        m_kind  = (rl != 0) ? 2 : 1;
      end else begin
        m_lanes = 0;
        m_kind  = 0;
      end
      if (m_lanes != 0) m_din = d_i;
    end
  end

  task automatic compare_now();
    bit exp_oe;
    exp_oe = !oe_n && (m_kind != 2) && (m_vld || m_tail);
    n_chk++;
    if (dq_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s dq_oe actual=%0b expected=%0b t=%0t", cur_req, dq_oe, exp_oe, $time);
    end
    if (exp_oe) begin
      for (int i = 0; i < 4; i++) begin
        if (m_dk[i]) begin
          n_chk++;
          if (q_o[i*LW +: LW] !== m_dout[i*LW +: LW]) begin
            n_bad++;
            $display("FAIL %s lane%0d actual=%h expected=%h t=%0t", cur_req, i,
                     q_o[i*LW +: LW], m_dout[i*LW +: LW], $time);
          end
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) compare_now();
  end

  // stimulus helpers: inputs move one unit after the falling edge
  task automatic put(input logic p_n, input logic c_n, input logic e0, input logic e1,
                     input logic e2, input logic g_n, input logic be_n, input logic [3:0] b_n,
                     input int a, input logic [DATA_W-1:0] d);
    @(negedge clk); #1;
    adsp_n = p_n; adsc_n = c_n; ce0_n = e0; ce1 = e1; ce2_n = e2;
    gw_n = g_n; bwe_n = be_n; bw_n = b_n; addr_i = ADDR_W'(a); d_i = d;
  endtask

  task automatic rdp(input int a);
    put(0, 1, 0, 1, 0, 1, 1, 4'hF, a, '0);
  endtask
  task automatic rdc(input int a);
    put(1, 0, 0, 1, 0, 1, 1, 4'hF, a, '0);
  endtask
  task automatic wrc(input int a, input logic [DATA_W-1:0] d, input logic g_n,
                     input logic be_n, input logic [3:0] b_n);
    put(1, 0, 0, 1, 0, g_n, be_n, b_n, a, d);
  endtask
  task automatic hold(input logic be_n, input logic [3:0] b_n, input logic [DATA_W-1:0] d);
    put(1, 1, 0, 1, 0, 1, be_n, b_n, 0, d);
  endtask
  task automatic dsel();
    put(1, 0, 0, 0, 0, 1, 1, 4'hF, 0, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) hold(1, 4'hF, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state undriven
    repeat (3) @(negedge clk);
    n_chk++;
    if (dq_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset dq_oe actual=%0b expected=0", dq_oe);
    end
    @(negedge clk); #1 rst_n = 1'b1;
    dsel();
    idle(4);

    cur_req = "R2";
    wrc(5, 36'hA_BCDE_F012, 0, 1, 4'hF);
    cur_req = "R1";
    rdp(5); idle(3);
    dsel(); idle(3);

    cur_req = "R3";
    wrc(6, 36'h1_1111_1111, 0, 0, 4'h0);
    wrc(6, 36'h2_2222_2222, 1, 0, 4'b1010);
    wrc(6, 36'h3_3333_3333, 1, 1, 4'b0000);
    rdp(6); idle(2);

    cur_req = "R4";
    put(0, 0, 0, 1, 0, 0, 0, 4'h0, 7, 36'hF_FFFF_FFFF);
    hold(0, 4'b1110, 36'h0_0000_0155);
    rdp(7); idle(2);

    cur_req = "R6";
    put(0, 0, 1, 1, 0, 1, 1, 4'hF, 9, '0);
    idle(2);
    put(1, 0, 1, 1, 0, 1, 1, 4'hF, 5, '0);
    idle(3);
    put(1, 0, 0, 1, 1, 1, 1, 4'hF, 5, '0);
    idle(3);
    rdp(5);
    put(1, 1, 1, 0, 1, 1, 1, 4'hF, 0, '0);
    idle(2);

    cur_req = "R7";
    rdp(6); idle(1); dsel(); idle(4);
    rdp(5); dsel(); rdp(6); idle(2);

    cur_req = "R8";
    rdp(5); idle(1);
    @(posedge clk); #2 oe_n = 1'b1;
    #1 n_chk++;
    if (dq_oe !== 1'b0) begin n_bad++; $display("FAIL R8 dq_oe actual=%0b expected=0", dq_oe); end
    oe_n = 1'b0;
    #1 n_chk++;
    if (dq_oe !== 1'b1) begin n_bad++; $display("FAIL R8 dq_oe actual=%0b expected=1", dq_oe); end
    oe_n = 1'b1; idle(2);
    oe_n = 1'b0; idle(1);

    cur_req = "R5";
    rdp(5); idle(1);
    wrc(8, 36'h5_A5A5_A5A5, 0, 1, 4'hF);
    idle(1);

    cur_req = "R9";
    wrc(8, 36'h0_0000_0000, 1, 0, 4'b0110);
    rdc(8); idle(2);

    cur_req = "R10";
    wrc(10, 36'h8_0402_0100, 0, 1, 4'hF);
    rdc(10); idle(1);
    wrc(10, 36'h0_0000_0000, 1, 0, 4'b0111);
    rdc(10); idle(2);

    cur_req = "R11";
    rdp(5); idle(3);
    hold(0, 4'b0111, 36'h7_7000_0000);
    idle(2);
    dsel(); idle(3);

    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      int op;
      int a;
      logic [DATA_W-1:0] d;
      op = int'($urandom % 7);
      a  = int'($urandom % 8);
      d  = {$urandom, $urandom};
      oe_n = (($urandom % 10) == 0);
      case (op)
        0: rdp(a);
        1: rdc(a);
        2: wrc(a, d, 0, 1, 4'hF);
        3: wrc(a, d, 1, 0, 4'($urandom));
        4: hold(0, 4'($urandom), d);
        5: dsel();
        default: hold(1, 4'hF, d);
      endcase
    end
    oe_n = 1'b0;
    idle(4);

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule